// File: doc/BRIEF.md
# I2C Slave Address and Reserved-Code Decoder

This block sits at the receive side of a two-wire serial slave. It watches the filtered clock and data lines and finds start, repeated-start and stop conditions. After every start it shifts in the first byte, most significant bit first. It then classifies that byte against the slave's programmable 7-bit address and against the reserved first-byte codes. The block acknowledges only the codes that belong to it, by pulling the data line low for the ninth clock.

When a general call is accepted, the block also takes in the following byte. If the low bit of that byte is 0, the byte is a command: one value asks for a reset plus a reload of the programmable address bits, another asks for a reload only, and every other command is acknowledged with no action. If the low bit is 1, the upper seven bits are the address of the master that sent it. That address is presented on a port. The data phase that follows an address, and the rest of a 10-bit address exchange, are handled elsewhere.

Top module: `i2ca_decoder`

## Requirements
- R1: On each rising SCL edge after a start, one SDA bit is shifted in, most significant bit first. The clock cycle in which the eighth bit is sampled is followed by a one-cycle `addr_done_o` pulse. In that same cycle `addr_o` takes the upper seven bits and `rw_o` takes the last bit (0 = master writes, 1 = master reads). These values are held until the next start or stop.
- R2: When the received address equals `own_addr_i` and is not a reserved code, `match_o` is set. `sda_pull_o` rises on the SCL falling edge that follows the eighth bit and drops on the SCL falling edge that ends the ninth clock.
- R3: Byte 0x00 (address 0000000, direction 0) sets `gcall_o`. It is acknowledged only when `gc_en_i` is 1.
- R4: Byte 0x01 (address 0000000, direction 1) sets `start_byte_o` and is never acknowledged.
- R5: Address 0000001 with either direction sets `cbus_o` and is never acknowledged.
- R6: Addresses 00001xx set `hs_code_o` and addresses 11110xx set `tenbit_o`. Neither is acknowledged.
- R7: Any other address that differs from `own_addr_i` sets no flag and leaves `sda_pull_o` low. At most one classification flag is ever high.
- R8: For the byte after an accepted general call, 0x06 gives a one-cycle `gc_reset_o` pulse and 0x04 gives a one-cycle `gc_reload_o` pulse. Both pulses come in the cycle after the eighth bit. Other command bytes with the low bit at 0 give no pulse. The byte is acknowledged in every case.
- R9: If that byte has its low bit at 1, `gc_master_valid_o` pulses for one cycle, `gc_master_addr_o` takes the upper seven bits, and the byte is acknowledged.
- R10: A repeated start restarts address reception from the first bit and clears the flags, with no stop needed in between.
- R11: A stop, or a start in the middle of a byte, aborts reception. The bit count returns to zero, `sda_pull_o` drops, and the flags clear.
- R12: After a general call that was not accepted, or after any other address, later bytes produce no command pulses and no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Filtered serial clock line |
| sda_i | input | 1 | Filtered serial data line (wired-AND level) |
| sda_pull_o | output | 1 | Drives SDA low when 1 |
| own_addr_i | input | 7 | Programmable own address |
| gc_en_i | input | 1 | Enables acknowledge of general calls |
| addr_done_o | output | 1 | One-cycle pulse when the first byte is complete |
| addr_o | output | 7 | Received 7-bit address |
| rw_o | output | 1 | Received direction bit |
| match_o | output | 1 | Own address matched |
| gcall_o | output | 1 | General call seen |
| start_byte_o | output | 1 | Start byte seen |
| cbus_o | output | 1 | CBUS code seen |
| hs_code_o | output | 1 | High-speed master code seen |
| tenbit_o | output | 1 | 10-bit prefix seen |
| gc_reset_o | output | 1 | Reset-and-reload command pulse |
| gc_reload_o | output | 1 | Reload-only command pulse |
| gc_master_valid_o | output | 1 | Master address from a general call is valid |
| gc_master_addr_o | output | 7 | Master address carried by a general call |

## Verification
The assertions assume the SCL and SDA inputs are already free of glitches and that each level holds for at least two sampling cycles. They also assume SDA changes only while SCL is low, except when the master is making a start or a stop. The stimulus moves SCL and SDA at a quarter-bit spacing of four clock cycles and never changes both in the same cycle. The data line the block sees is the wired-AND of the master's drive and the block's own pull-down. Repeated starts are issued only after the acknowledge slot, while the block is not pulling SDA.

// File: rtl/i2ca_pkg.sv
package i2ca_pkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = BYTE_W - 1;
  localparam int PFX_W  = ADDR_W - 2;
  localparam logic [PFX_W-1:0] HS_PREFIX  = 5'b00001;
  localparam logic [PFX_W-1:0] TEN_PREFIX = 5'b11110;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_AWAIT, PH_AACK,
    PH_CMD,  PH_CWAIT, PH_CACK, PH_HOLD
  } phase_e;

  typedef struct packed {
    logic own;
    logic gcall;
    logic sbyte;
    logic cbus;
    logic hsm;
    logic tenb;
  } kind_t;

  // Classify a completed first byte.
  function automatic kind_t classify(input logic [ADDR_W-1:0] a,
                                     input logic              rw,
                                     input logic [ADDR_W-1:0] own);
    kind_t k;
    logic  rsv;
    k       = '0;
    k.gcall = (a == '0) && !rw;
    k.sbyte = (a == '0) && rw;
    k.cbus  = (a == ADDR_W'(1));
    k.hsm   = (a[ADDR_W-1:2] == HS_PREFIX);
    k.tenb  = (a[ADDR_W-1:2] == TEN_PREFIX);
    rsv     = k.gcall | k.sbyte | k.cbus | k.hsm | k.tenb;
    k.own   = (a == own) && !rsv;
    return k;
  endfunction

  // Command action: {reset_and_reload, reload_only}.
  function automatic logic [1:0] gc_action(input logic [BYTE_W-1:0] cmd,
                                           input logic [BYTE_W-1:0] rst_code,
                                           input logic [BYTE_W-1:0] rld_code);
    if (cmd[0])               return 2'b00;
    else if (cmd == rst_code) return 2'b10;
    else if (cmd == rld_code) return 2'b01;
    else                      return 2'b00;
  endfunction

endpackage

// File: rtl/i2ca_line_events.sv
module i2ca_line_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_evt = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_evt  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2ca_byte_shifter.sv
module i2ca_byte_shifter #(
  parameter int W  = 8,
  localparam int CW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         shift_en,
  input  logic         bit_i,
  output logic [W-1:0] next_byte,
  output logic         full,
  output logic         cnt_zero
);
  logic [W-1:0]  sr_q;
  logic [CW-1:0] cnt_q;

  assign next_byte = {sr_q[W-2:0], bit_i};
  assign full      = shift_en && (cnt_q == CW'(W-1));
  assign cnt_zero  = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (shift_en) begin
      sr_q  <= next_byte;
      cnt_q <= full ? '0 : cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/i2ca_classifier.sv
module i2ca_classifier
  import i2ca_pkg::*;
(
  input  logic [BYTE_W-1:0] first_byte,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              gc_en,
  output kind_t             kind,
  output logic              ack
);
  always_comb begin
    kind = classify(first_byte[BYTE_W-1:1], first_byte[0], own_addr);
    ack  = kind.own | (kind.gcall & gc_en);
  end
endmodule

// File: rtl/i2ca_decoder.sv
module i2ca_decoder
  import i2ca_pkg::*;
#(
  parameter logic [7:0] GC_RESET_CMD  = 8'h06,
  parameter logic [7:0] GC_RELOAD_CMD = 8'h04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              gc_en_i,
  output logic              addr_done_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              rw_o,
  output logic              match_o,
  output logic              gcall_o,
  output logic              start_byte_o,
  output logic              cbus_o,
  output logic              hs_code_o,
  output logic              tenbit_o,
  output logic              gc_reset_o,
  output logic              gc_reload_o,
  output logic              gc_master_valid_o,
  output logic [ADDR_W-1:0] gc_master_addr_o
);
  // Named internal events
  logic scl_rise, scl_fall, start_evt, stop_evt;
  logic shift_en, byte_full, cnt_zero;
  logic [BYTE_W-1:0] byte_now;
  kind_t cls_kind;
  logic  cls_ack;
  logic [1:0] cmd_act;

  phase_e phase_q;
  kind_t  kind_q;
  logic   ack_q, pull_q, rw_q, done_q;
  logic   rst_p_q, rld_p_q, mval_q;
  logic [ADDR_W-1:0] addr_q, maddr_q;

  i2ca_line_events u_ev (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  assign shift_en = scl_rise && (phase_q == PH_ADDR || phase_q == PH_CMD);

  i2ca_byte_shifter #(.W(BYTE_W)) u_sh (
    .clk(clk), .rst_n(rst_n), .clear(start_evt | stop_evt),
    .shift_en(shift_en), .bit_i(sda_i),
    .next_byte(byte_now), .full(byte_full), .cnt_zero(cnt_zero)
  );

  i2ca_classifier u_cls (
    .first_byte(byte_now), .own_addr(own_addr_i), .gc_en(gc_en_i),
    .kind(cls_kind), .ack(cls_ack)
  );

  assign cmd_act = gc_action(byte_now, GC_RESET_CMD, GC_RELOAD_CMD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      kind_q  <= '0;
      ack_q   <= 1'b0;
      pull_q  <= 1'b0;
      rw_q    <= 1'b0;
      addr_q  <= '0;
      done_q  <= 1'b0;
      rst_p_q <= 1'b0;
      rld_p_q <= 1'b0;
      mval_q  <= 1'b0;
      maddr_q <= '0;
    end else begin
      done_q  <= 1'b0;
      rst_p_q <= 1'b0;
      rld_p_q <= 1'b0;
      mval_q  <= 1'b0;
      if (start_evt || stop_evt) begin
        phase_q <= start_evt ? PH_ADDR : PH_IDLE;
        kind_q  <= '0;
        ack_q   <= 1'b0;
        pull_q  <= 1'b0;
        rw_q    <= 1'b0;
        addr_q  <= '0;
      end else begin
        unique case (phase_q)
          PH_ADDR: if (byte_full) begin
            kind_q  <= cls_kind;
            ack_q   <= cls_ack;
            addr_q  <= byte_now[BYTE_W-1:1];
            rw_q    <= byte_now[0];
            done_q  <= 1'b1;
            phase_q <= PH_AWAIT;
          end
          PH_AWAIT: if (scl_fall) begin
            pull_q  <= ack_q;
            phase_q <= PH_AACK;
          end
          PH_AACK: if (scl_fall) begin
            pull_q  <= 1'b0;
            phase_q <= (ack_q && kind_q.gcall) ? PH_CMD : PH_HOLD;
          end
          PH_CMD: if (byte_full) begin
            rst_p_q <= cmd_act[1];
            rld_p_q <= cmd_act[0];
            mval_q  <= byte_now[0];
            if (byte_now[0]) maddr_q <= byte_now[BYTE_W-1:1];
            phase_q <= PH_CWAIT;
          end
          PH_CWAIT: if (scl_fall) begin
            pull_q  <= 1'b1;
            phase_q <= PH_CACK;
          end
          PH_CACK: if (scl_fall) begin
            pull_q  <= 1'b0;
            phase_q <= PH_HOLD;
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull_o        = pull_q;
  assign addr_done_o       = done_q;
  assign addr_o            = addr_q;
  assign rw_o              = rw_q;
  assign match_o           = kind_q.own;
  assign gcall_o           = kind_q.gcall;
  assign start_byte_o      = kind_q.sbyte;
  assign cbus_o            = kind_q.cbus;
  assign hs_code_o         = kind_q.hsm;
  assign tenbit_o          = kind_q.tenb;
  assign gc_reset_o        = rst_p_q;
  assign gc_reload_o       = rld_p_q;
  assign gc_master_valid_o = mval_q;
  assign gc_master_addr_o  = maddr_q;
endmodule

// File: rtl/i2ca_chk.sv
module i2ca_chk (
  input logic clk,
  input logic rst_n,
  input logic sda_pull_o,
  input logic match_o,
  input logic gcall_o,
  input logic start_byte_o,
  input logic cbus_o,
  input logic hs_code_o,
  input logic tenbit_o,
  input logic gc_reset_o,
  input logic gc_reload_o,
  input logic gc_master_valid_o,
  input logic scl_fall,
  input logic start_evt,
  input logic stop_evt,
  input logic cnt_zero
);
  // R2
  pull_edge_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_pull_o) || $fell(sda_pull_o)) |-> $past(scl_fall || start_evt || stop_evt));
  // R4
  reserved_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_byte_o || cbus_o || hs_code_o || tenbit_o) |-> !sda_pull_o);
  // R7
  one_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({match_o, gcall_o, start_byte_o, cbus_o, hs_code_o, tenbit_o}));
  // R8
  cmd_pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gc_reset_o && gc_reload_o));
  // R8
  reset_pulse_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gc_reset_o |=> !gc_reset_o);
  // R9
  master_addr_after_gc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gc_master_valid_o |-> gcall_o);
  // R11
  stop_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (!sda_pull_o && cnt_zero && !match_o));
  // R10
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (cnt_zero && !gcall_o && !match_o));
endmodule

bind i2ca_decoder i2ca_chk u_chk (.*);

// File: tb/i2ca_decoder_tb.sv
`timescale 1ns/1ps
module i2ca_decoder_tb;
  localparam int HB = 4;
  localparam logic [6:0] OWN = 7'h3A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic gc_en = 1'b1;
  logic sda_line;
  logic pull, done, rw, match, gcall, sbyte, cbus, hsc, tenb, grst, grld, gmv;
  logic [6:0] addr, gmaddr;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int c_rst = 0, c_rld = 0, c_mv = 0;

  always #2.5 clk = ~clk;
  assign sda_line = m_sda & ~pull;

  i2ca_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_pull_o(pull), .own_addr_i(OWN), .gc_en_i(gc_en),
    .addr_done_o(done), .addr_o(addr), .rw_o(rw), .match_o(match),
    .gcall_o(gcall), .start_byte_o(sbyte), .cbus_o(cbus),
    .hs_code_o(hsc), .tenbit_o(tenb), .gc_reset_o(grst),
    .gc_reload_o(grld), .gc_master_valid_o(gmv), .gc_master_addr_o(gmaddr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Behavioural reference model, integer based
  int ps, pd, mode, nb, acc, e_ack;
  int e_pull, e_done, e_addr, e_rw, e_m, e_gc, e_sb, e_cb, e_hs, e_tb;
  int e_rst, e_rld, e_mv, e_ma;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      ps = 1; pd = 1; mode = 0; nb = 0; acc = 0; e_ack = 0;
      e_pull = 0; e_done = 0; e_addr = 0; e_rw = 0;
      e_m = 0; e_gc = 0; e_sb = 0; e_cb = 0; e_hs = 0; e_tb = 0;
      e_rst = 0; e_rld = 0; e_mv = 0; e_ma = 0;
    end else begin
      int cs, cd, a;
      cs = int'(m_scl); cd = int'(sda_line);
      e_done = 0; e_rst = 0; e_rld = 0; e_mv = 0;
      if (cs == 1 && ps == 1 && pd != cd) begin
        mode = (cd == 0) ? 1 : 0;
        nb = 0; acc = 0; e_pull = 0; e_ack = 0; e_addr = 0; e_rw = 0;
        e_m = 0; e_gc = 0; e_sb = 0; e_cb = 0; e_hs = 0; e_tb = 0;
      end else if ((mode == 1 || mode == 4) && cs == 1 && ps == 0) begin
        acc = acc * 2 + cd; nb++;
        if (nb == 8) begin
          if (mode == 1) begin
            a = acc / 2;
            e_addr = a; e_rw = acc % 2; e_done = 1;
            e_gc = (acc == 0); e_sb = (acc == 1); e_cb = (a == 1);
            e_hs = (a >= 4 && a <= 7); e_tb = (a >= 120 && a <= 123);
            e_m  = (a == OWN) && !(e_gc || e_sb || e_cb || e_hs || e_tb);
            e_ack = e_m || (e_gc && gc_en);
          end else begin
            if (acc % 2 == 1) begin e_mv = 1; e_ma = acc / 2; end
            else if (acc == 6) e_rst = 1;
            else if (acc == 4) e_rld = 1;
          end
          mode = mode + 1; nb = 0; acc = 0;
        end
      end else if (cs == 0 && ps == 1) begin
        case (mode)
          2: begin e_pull = e_ack; mode = 3; end
          3: begin e_pull = 0; mode = (e_ack && e_gc) ? 4 : 7; end
          5: begin e_pull = 1; mode = 6; end
          6: begin e_pull = 0; mode = 7; end
          default: ;
        endcase
      end
      ps = cs; pd = cd;
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) if (rst_n) begin
    chk(int'(pull) == e_pull, "R2 sda_pull", pull, e_pull);
    chk(int'(done) == e_done, "R1 addr_done", done, e_done);
    chk(int'(addr) == e_addr, "R1 addr", addr, e_addr);
    chk(int'(rw) == e_rw, "R1 rw", rw, e_rw);
    chk(int'(match) == e_m, "R7 match", match, e_m);
    chk(int'(gcall) == e_gc, "R3 gcall", gcall, e_gc);
    chk(int'(sbyte) == e_sb, "R4 start_byte", sbyte, e_sb);
    chk(int'(cbus) == e_cb, "R5 cbus", cbus, e_cb);
    chk(int'(hsc) == e_hs, "R6 hs_code", hsc, e_hs);
    chk(int'(tenb) == e_tb, "R6 tenbit", tenb, e_tb);
    chk(int'(grst) == e_rst, "R8 gc_reset", grst, e_rst);
    chk(int'(grld) == e_rld, "R8 gc_reload", grld, e_rld);
    chk(int'(gmv) == e_mv, "R9 gc_master_valid", gmv, e_mv);
    chk(int'(gmaddr) == e_ma, "R9 gc_master_addr", gmaddr, e_ma);
    if (grst) c_rst++;
    if (grld) c_rld++;
    if (gmv)  c_mv++;
  end

  task automatic hb(); repeat (HB) @(negedge clk); endtask

  task automatic do_start();
    m_sda = 1'b1; hb(); m_scl = 1'b1; hb(); m_sda = 1'b0; hb(); m_scl = 1'b0; hb();
  endtask

  task automatic do_stop();
    m_sda = 1'b0; hb(); m_scl = 1'b1; hb(); m_sda = 1'b1; hb();
  endtask

  task automatic do_bit(input logic b);
    m_sda = b; hb(); m_scl = 1'b1; hb(); m_scl = 1'b0; hb();
  endtask

  task automatic do_byte(input logic [7:0] v, output bit acked);
    for (int i = 7; i >= 0; i--) do_bit(v[i]);
    m_sda = 1'b1; hb(); m_scl = 1'b1; hb();
    acked = (sda_line == 1'b0);
    m_scl = 1'b0; hb();
  endtask

  task automatic first_byte(input logic [7:0] v, input bit exp_ack, input string req);
    bit ak;
    do_start();
    do_byte(v, ak);
    chk(ak == exp_ack, req, ak, exp_ack);
  endtask

  initial begin : wd
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit ak;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pull == 1'b0 && match == 1'b0 && done == 1'b0, "R1 reset state", pull, 0);

    // R2 own address, write then read
    first_byte({OWN, 1'b0}, 1, "R2 own write ack");
    chk(match && !rw, "R1 write direction", rw, 0);
    do_stop();
    first_byte({OWN, 1'b1}, 1, "R2 own read ack");
    chk(rw == 1'b1, "R1 read direction", rw, 1);
    do_stop();

    // R7 foreign address
    first_byte(8'hAA, 0, "R7 foreign no ack");
    do_byte(8'h06, ak);
    chk(ak == 0 && c_rst == 0, "R12 byte after foreign", ak, 0);
    do_stop();

    // R3 R8 R9 general call accepted
    first_byte(8'h00, 1, "R3 gc ack enabled");
    do_byte(8'h06, ak);
    chk(ak == 1 && c_rst == 1, "R8 reset cmd", c_rst, 1);
    do_stop();
    first_byte(8'h00, 1, "R3 gc ack enabled");
    do_byte(8'h04, ak);
    chk(ak == 1 && c_rld == 1, "R8 reload cmd", c_rld, 1);
    do_stop();
    first_byte(8'h00, 1, "R3 gc ack enabled");
    do_byte(8'h08, ak);
    chk(ak == 1 && c_rst == 1 && c_rld == 1, "R8 other cmd no action", ak, 1);
    do_stop();
    first_byte(8'h00, 1, "R3 gc ack enabled");
    do_byte(8'h6B, ak);
    chk(ak == 1 && c_mv == 1 && gmaddr == 7'h35, "R9 master address", gmaddr, 8'h35);
    do_stop();

    // R3 R12 general call disabled
    gc_en = 1'b0;
    first_byte(8'h00, 0, "R3 gc ignored when disabled");
    do_byte(8'h06, ak);
    chk(ak == 0 && c_rst == 1, "R12 cmd after rejected gc", c_rst, 1);
    do_stop();
    gc_en = 1'b1;

    // R4 R5 R6 reserved codes
    first_byte(8'h01, 0, "R4 start byte no ack");
    do_stop();
    first_byte(8'h02, 0, "R5 cbus write no ack");
    do_stop();
    first_byte(8'h03, 0, "R5 cbus read no ack");
    do_stop();
    first_byte(8'h0A, 0, "R6 hs code no ack");
    do_stop();
    first_byte(8'hF3, 0, "R6 tenbit prefix no ack");
    do_stop();

    // R10 repeated start after a foreign address
    first_byte(8'h55, 0, "R7 foreign no ack");
    first_byte({OWN, 1'b0}, 1, "R10 repeated start then own");
    do_stop();

    // R11 stop mid-byte, then fresh address
    do_start();
    do_bit(1'b1); do_bit(1'b0); do_bit(1'b1);
    do_stop();
    chk(pull == 1'b0, "R11 released after stop", pull, 0);
    first_byte({OWN, 1'b1}, 1, "R11 own after abort");
    do_stop();

    // R11 start mid-byte
    do_start();
    do_bit(1'b0); do_bit(1'b1); do_bit(1'b1);
    first_byte({OWN, 1'b0}, 1, "R11 start mid-byte realigns");
    do_stop();

    repeat (10) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule